// File: doc/BRIEF.md
# Two-Operand Addressing-Mode Add Executor

This block is a small multicycle 16-bit execution core. It runs one kind of work: a two-operand add, where each operand sits in a location chosen by one of four addressing modes. The core has sixteen 16-bit general registers and a program counter. It reaches one single-port, word-addressed memory through a request/ready handshake.

A sequencer fetches the instruction word, then any extension words. It resolves the source location and then the destination location, applying post-increment side effects along the way. It adds the two operand values and stores the sum back to the destination. The destination can be a register or a memory word.

A done pulse marks the end of each instruction. Debug read ports expose the register file and program counter, so the surrounding logic or a bench can compare the core against an architectural model.

Top module: `amx_core`

## Requirements
- R1: The instruction word is decoded as opcode in bits 15:12, source mode in bits 11:10, destination mode in bits 9:8, source register in bits 7:4 and destination register in bits 3:0; opcode 0 selects the add.
- R2: A word with a nonzero opcode is a no-op occupying one word: only the program counter changes, by 1, and a done pulse is still given.
- R3: Mode 0 (register direct) reads the operand from the register; as a destination, the sum is written into that register and memory is not written.
- R4: Mode 1 (register indirect) uses the memory word whose address is the register value; as a destination, that word receives the sum.
- R5: Mode 2 (indirect with post-increment) addresses memory with the register value and adds 1 to the register exactly once, when the operand is read; a destination store goes to the address taken before the increment.
- R6: Mode 3 (indexed) addresses memory at the register value plus a 16-bit extension word, and the address sum wraps modulo 2^16.
- R7: An extension word follows the instruction only for an operand in mode 3, the source's before the destination's; the program counter advances by 1 plus the number of extension words.
- R8: The source operand, including its increment, is complete before the destination register is read, so a destination naming the same register sees the incremented value.
- R9: The destination receives the 16-bit two's complement sum of the source and destination values read before the store, wrapping on overflow.
- R10: The memory port has one request at a time; while the request is up and ready has not arrived, the request, write enable, address and write data stay unchanged, and the core waits for as many cycles as needed.
- R11: Synchronous active-high reset clears the program counter and all registers; after reset the core fetches from address 0.
- R12: The done output is a one-cycle pulse, given once per instruction, in the cycle after the instruction's final access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write when high |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Access completed; read data valid in this cycle |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle pulse at the end of each instruction |
| dbg_idx | input | 4 | Register index for the debug read port |
| dbg_reg | output | 16 | Value of the register selected by dbg_idx |
| dbg_pc | output | 16 | Current program counter |

## Verification
Every architectural effect of an instruction is final at the clock edge that raises done. That edge writes the register for a register destination. A memory store has already landed when the memory model raised ready one cycle earlier. The bench therefore waits for done at falling clock edges and only then compares the program counter, all sixteen registers and the memory image against its own model. One cycle later it confirms that done has dropped. The memory model inserts 0 to 2 wait cycles per access, which varies the cycle in which each result becomes due. The checks are tied to done rather than to a fixed cycle count, so they keep to the right cycle under every latency.

// File: rtl/amx_pkg.sv
package amx_pkg;

    localparam int WORD_W    = 16;
    localparam int REG_COUNT = 16;

    typedef enum logic [1:0] {
        AM_REG  = 2'd0,
        AM_IND  = 2'd1,
        AM_PINC = 2'd2,
        AM_IDX  = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EXTS,
        ST_EXTD,
        ST_SRC,
        ST_DST,
        ST_WB
    } state_e;

    // Field placement is fixed by the instruction encoding
    typedef struct packed {
        logic [3:0] op;
        amode_e     sm;
        amode_e     dm;
        logic [3:0] rs;
        logic [3:0] rd;
    } insn_t;

    function automatic logic needs_ext(amode_e m);
        return m == AM_IDX;
    endfunction

    function automatic state_e after_fetch(insn_t w);
        if (needs_ext(w.sm)) return ST_EXTS;
        if (needs_ext(w.dm)) return ST_EXTD;
        return ST_SRC;
    endfunction

endpackage

// File: rtl/amx_regbank.sv
module amx_regbank #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    input  logic [RW-1:0] rc,
    input  logic          we,
    input  logic [RW-1:0] wa,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] qa,
    output logic [DW-1:0] qb,
    output logic [DW-1:0] qc
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (we && wa == RW'(i))
                regs[i] <= wd;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];
    assign qc = regs[rc];

endmodule

// File: rtl/amx_locator.sv
module amx_locator
    import amx_pkg::*;
#(
    parameter int DW = 16
) (
    input  amode_e        mode,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] ext,
    output logic [DW-1:0] addr,
    output logic          in_mem
);
    // Indexed sum wraps naturally at DW bits
    assign addr   = (mode == AM_IDX) ? base + ext : base;
    assign in_mem = (mode != AM_REG);
endmodule

// File: rtl/amx_core.sv
module amx_core
    import amx_pkg::*;
#(
    parameter int DW   = WORD_W,
    parameter int NREG = REG_COUNT,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    input  logic [RW-1:0] dbg_idx,
    output logic [DW-1:0] dbg_reg,
    output logic [DW-1:0] dbg_pc
);
    state_e        state;
    insn_t         ir;
    insn_t         fetched;
    logic [DW-1:0] pc, ext_s, ext_d, sval, dval, dst_addr, sum;
    logic [DW-1:0] qa, qb, src_loc, dst_loc;
    logic          src_mem, dst_mem, done_q;
    logic          rf_we;
    logic [RW-1:0] rf_wa;
    logic [DW-1:0] rf_wd;

    assign fetched = insn_t'(mem_rdata[15:0]);
    assign sum     = sval + dval;

    amx_regbank #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .ra(ir.rs), .rb(ir.rd), .rc(dbg_idx),
        .we(rf_we), .wa(rf_wa), .wd(rf_wd),
        .qa(qa), .qb(qb), .qc(dbg_reg)
    );

    amx_locator #(.DW(DW)) u_src_loc (
        .mode(ir.sm), .base(qa), .ext(ext_s), .addr(src_loc), .in_mem(src_mem)
    );

    amx_locator #(.DW(DW)) u_dst_loc (
        .mode(ir.dm), .base(qb), .ext(ext_d), .addr(dst_loc), .in_mem(dst_mem)
    );

    // Memory request and register-file write selection
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc;
        mem_wdata = sum;
        rf_we     = 1'b0;
        rf_wa     = ir.rd;
        rf_wd     = sum;
        unique case (state)
            ST_FETCH, ST_EXTS, ST_EXTD: mem_req = 1'b1;
            ST_SRC: begin
                mem_req  = src_mem;
                mem_addr = src_loc;
                if (ir.sm == AM_PINC && mem_ready) begin
                    rf_we = 1'b1;
                    rf_wa = ir.rs;
                    rf_wd = qa + DW'(1);
                end
            end
            ST_DST: begin
                mem_req  = dst_mem;
                mem_addr = dst_loc;
                if (ir.dm == AM_PINC && mem_ready) begin
                    rf_we = 1'b1;
                    rf_wd = qb + DW'(1);
                end
            end
            ST_WB: begin
                mem_req  = dst_mem;
                mem_we   = dst_mem;
                mem_addr = dst_addr;
                rf_we    = !dst_mem;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FETCH;
            pc       <= '0;
            ir       <= '0;
            ext_s    <= '0;
            ext_d    <= '0;
            sval     <= '0;
            dval     <= '0;
            dst_addr <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_FETCH: if (mem_ready) begin
                    ir <= fetched;
                    pc <= pc + DW'(1);
                    if (fetched.op != 4'd0) done_q <= 1'b1;
                    else                    state  <= after_fetch(fetched);
                end
                ST_EXTS: if (mem_ready) begin
                    ext_s <= mem_rdata;
                    pc    <= pc + DW'(1);
                    state <= needs_ext(ir.dm) ? ST_EXTD : ST_SRC;
                end
                ST_EXTD: if (mem_ready) begin
                    ext_d <= mem_rdata;
                    pc    <= pc + DW'(1);
                    state <= ST_SRC;
                end
                ST_SRC: if (!src_mem || mem_ready) begin
                    sval  <= src_mem ? mem_rdata : qa;
                    state <= ST_DST;
                end
                ST_DST: if (!dst_mem || mem_ready) begin
                    dval     <= dst_mem ? mem_rdata : qb;
                    dst_addr <= dst_loc;
                    state    <= ST_WB;
                end
                ST_WB: if (!dst_mem || mem_ready) begin
                    done_q <= 1'b1;
                    state  <= ST_FETCH;
                end
                default: state <= ST_FETCH;
            endcase
        end
    end

    assign done   = done_q;
    assign dbg_pc = pc;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == '0 && state == ST_FETCH && !mem_we));

    // R5
    pinc_store_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WB && ir.dm == AM_PINC) |-> (mem_we && mem_addr == qb - DW'(1)));

endmodule

// File: tb/sim_amx_core.sv
module sim_amx_core;
    localparam int CLK_PERIOD = 10;
    localparam int NPROG      = 16;
    localparam int MEMW       = 1024;

    // {instruction, source extension, destination extension}
    localparam logic [47:0] PROG [NPROG] = '{
        {16'h0C01, 16'h0200, 16'h0000},
        {16'h0C02, 16'h0201, 16'h0000},
        {16'h0C03, 16'h0202, 16'h0000},
        {16'h0C04, 16'h0203, 16'h0000},
        {16'h0C05, 16'h0204, 16'h0000},
        {16'h0034, 16'h0000, 16'h0000},
        {16'h0033, 16'h0000, 16'h0000},
        {16'h0416, 16'h0000, 16'h0000},
        {16'h0A11, 16'h0000, 16'h0000},
        {16'h0132, 16'h0000, 16'h0000},
        {16'h0F52, 16'hFFFF, 16'h0004},
        {16'h5123, 16'h0000, 16'h0000},
        {16'h0E02, 16'h0205, 16'h0000},
        {16'h0822, 16'h0000, 16'h0000},
        {16'h0361, 16'h0000, 16'h0010},
        {16'h0911, 16'h0000, 16'h0000}
    };
    string TAGS [NPROG] = '{"R6","R6","R6","R7","R1","R9","R3","R4",
                            "R8","R4","R7","R2","R5","R8","R7","R5"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we, mem_ready, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_reg, dbg_pc;
    logic [3:0]  dbg_idx = '0;

    logic [15:0] mem  [MEMW];
    logic [15:0] img  [MEMW];
    logic [15:0] rreg [16];
    logic [15:0] rpc;
    logic        ld_en = 1'b0;
    logic [9:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    int          lat = 0;
    int          wcnt = 0;
    int          checks = 0;
    int          fails = 0;
    bit          hung = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amx_core u0 (
        .clk(clk), .rst(rst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done(done), .dbg_idx(dbg_idx), .dbg_reg(dbg_reg), .dbg_pc(dbg_pc)
    );

    // Memory model with a programmable number of wait cycles
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        if (rst) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
        end else if (mem_req && !mem_ready) begin
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                wcnt      <= 0;
                if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:0]];
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Architectural model written from the requirements
    task automatic model_step();
        logic [15:0] w, es, ed, sv, dv, a;
        logic [1:0]  sm, dm;
        logic [3:0]  rs, rd;
        w = img[rpc[9:0]];
        rpc = rpc + 16'd1;
        if (w[15:12] != 4'd0) return;
        sm = w[11:10]; dm = w[9:8]; rs = w[7:4]; rd = w[3:0];
        es = '0; ed = '0;
        if (sm == 2'd3) begin es = img[rpc[9:0]]; rpc = rpc + 16'd1; end
        if (dm == 2'd3) begin ed = img[rpc[9:0]]; rpc = rpc + 16'd1; end
        if (sm == 2'd0) sv = rreg[rs];
        else begin
            a  = (sm == 2'd3) ? rreg[rs] + es : rreg[rs];
            sv = img[a[9:0]];
            if (sm == 2'd2) rreg[rs] = rreg[rs] + 16'd1;
        end
        a = '0;
        if (dm == 2'd0) dv = rreg[rd];
        else begin
            a  = (dm == 2'd3) ? rreg[rd] + ed : rreg[rd];
            dv = img[a[9:0]];
            if (dm == 2'd2) rreg[rd] = rreg[rd] + 16'd1;
        end
        if (dm == 2'd0) rreg[rd] = sv + dv;
        else            img[a[9:0]] = sv + dv;
    endtask

    task automatic wait_done(input string tag);
        bit seen = 1'b0;
        for (int c = 0; c < 400 && !seen; c++) begin
            @(negedge clk);
            seen = done;
        end
        if (!seen) begin
            hung = 1'b1;
            checks++; fails++;
            $display("FAIL %s done: actual 0 expected 1", tag);
        end
    endtask

    task automatic compare_all(input string tag);
        int bad = 0;
        check(tag, "pc", dbg_pc, rpc);
        for (int r = 0; r < 16; r++) begin
            dbg_idx = 4'(r);
            #1;
            check(tag, $sformatf("r%0d", r), dbg_reg, rreg[r]);
        end
        for (int m = 0; m < MEMW; m++) if (mem[m] !== img[m]) begin
            if (bad == 0) check(tag, $sformatf("mem[%0h]", m), mem[m], img[m]);
            bad++;
        end
        if (bad == 0) check(tag, "memory image", 16'd0, 16'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int p = 0;
        for (int m = 0; m < MEMW; m++) img[m] = '0;
        for (int i = 0; i < NPROG; i++) begin
            logic [15:0] w = PROG[i][47:32];
            img[p] = w; p++;
            if (w[15:12] == 4'd0 && w[11:10] == 2'd3) begin img[p] = PROG[i][31:16]; p++; end
            if (w[15:12] == 4'd0 && w[9:8] == 2'd3)   begin img[p] = PROG[i][15:0];  p++; end
        end
        for (int i = 0; i < 64; i++) img[10'h200 + i] = 16'h0A00 + 16'(i * 7);
        img[10'h200] = 16'h0220;
        img[10'h201] = 16'h0230;
        img[10'h202] = 16'h7FFF;
        img[10'h203] = 16'h8001;
        img[10'h204] = 16'h0102;
        for (int r = 0; r < 16; r++) rreg[r] = '0;
        rpc = '0;

        // Load memory while reset is held
        for (int m = 0; m < MEMW; m++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 10'(m); ld_data = img[m];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        compare_all("R11");
        rst = 1'b0;

        for (int i = 0; i < NPROG && !hung; i++) begin
            lat = i % 3;
            wait_done(TAGS[i]);
            if (hung) break;
            model_step();
            compare_all(TAGS[i]);
            @(negedge clk);
            check("R12", "done after pulse", {15'd0, done}, 16'd0);
        end

        // Reset in the middle of operation, then restart from address 0
        if (!hung) begin
            lat = 1;
            wait_done("R11");
            model_step();
            @(negedge clk);
            rst = 1'b1;
            repeat (2) @(negedge clk);
            for (int r = 0; r < 16; r++) rreg[r] = '0;
            rpc = '0;
            check("R11", "pc after reset", dbg_pc, 16'd0);
            dbg_idx = 4'd1; #1;
            check("R11", "r1 after reset", dbg_reg, 16'd0);
            rst = 1'b0;
            wait_done("R11");
            if (!hung) begin
                model_step();
                check("R11", "pc after first fetch", dbg_pc, 16'd2);
                dbg_idx = 4'd1; #1;
                check("R11", "r1 after first fetch", dbg_reg, img[10'h200]);
                compare_all("R11");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule